// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM of 256K bytes. The host raises a request with an address, a read/write flag and, for writes, a data byte. The sequencer then produces the complete pin-level cycle on the memory side. That cycle covers the address bus, an active-low select, an active-high select, the output-enable and write-enable strobes, and the enable for the write-data driver on the shared data bus. The block returns a one-cycle acknowledge when the access has finished. Read data is presented in the same cycle as the acknowledge and stays there until the next read completes.

Every phase of the memory cycle is counted out in whole clock cycles. Each count is the ceiling of a minimum time, held in picoseconds as a parameter, divided by the clock period parameter. Read strobes stay low long enough to cover cycle time, address access time and output-enable access time. A write holds back its data driver until the RAM can have released the bus. The write strobe then stays low long enough to cover the pulse width, the data setup time and the write cycle time. Both selects turn on with the first strobe and turn off one cycle after the strobe has returned high. As a result, every strobe lies wholly inside the select window.

With the default parameters the clock period is 10 ns. A read keeps the output enable low for 7 cycles. A write keeps the data bus undriven for 3 cycles, and the write enable is low for 7 cycles in total.

Top module: `sram_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), and whenever no access is in progress, mem_cs1_n is 1, mem_cs2 is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and ack is 0; rdata resets to 0.
- R2: A request (req=1, wr=0) sampled while idle starts a read. From the next cycle on, mem_cs1_n=0, mem_cs2=1, mem_oe_n=0 and mem_we_n=1, with mem_addr equal to the sampled addr.
- R3: A read keeps mem_oe_n low for exactly max(ceil(tRC), ceil(tAA), ceil(tOE)) cycles (7 by default). At the edge that ends this window the sequencer samples mem_dq_in into rdata. In the following cycle ack is 1, rdata is valid and mem_oe_n is 1.
- R4: A request with wr=1 sampled while idle starts a write. mem_we_n goes low in the next cycle with mem_oe_n high. mem_dq_oe stays 0 for the first ceil(tWHZ) cycles (3 by default). After that, mem_dq_out carries the sampled wdata with mem_dq_oe=1.
- R5: A write keeps mem_we_n low for max(ceil(tWP), ceil(tWC), ceil(tWHZ)+ceil(tDW)) cycles (7 by default). It is always low inside the select window, and ack is 1 in the first cycle with mem_we_n high again.
- R6: In the ack cycle both selects are still asserted with both strobes high, and for a write mem_dq_oe is still 1. The selects drop in the cycle after. mem_addr does not change while the selects are asserted.
- R7: ack is a single-cycle pulse. addr, wdata, wr and req are sampled only in the idle cycle that accepts a request; changes to them during an access have no effect on the memory pins.
- R8: mem_oe_n and mem_we_n are never low together, and mem_dq_oe is 1 only while the chip is selected with mem_oe_n high.
- R9: rdata changes only at the completion of a read. Writes and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| mem_addr | output | 18 | Memory address bus |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned from the memory bus |

## Verification
A request sampled at edge E0 changes the memory pins right after E0. The write driver enables after E0+3. The read sample and the ack follow E0+7, for both reads and writes, and the selects drop after E0+8. The bench's behavioural model advances a phase index at each rising edge from the same inputs the design sees. It compares every output at the following falling edge, so each check lands in the cycle where the register chain has already settled. The bench memory returns read data only at falling edges while the read strobes are asserted, so a capture made at the wrong edge shows up as wrong data.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and compile-time helpers for the SRAM access sequencer.
// Assumes all timing values are given in picoseconds as non-negative integers.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_REL,
        ST_WR_HZ,
        ST_WR_DAT,
        ST_WR_REL
    } seq_state_t;

    // Round a minimum time up to whole clock cycles, never fewer than one.
    function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
// Phase down-counter: loaded with (cycles-1) at a phase start and reports
// zero in the last cycle of the phase. Holds at zero when not reloaded.
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_rcap.sv
`timescale 1ns/1ps
// Read-data capture register: samples the memory bus on a capture strobe
// and holds the value until the next capture.
module sram_ctl_rcap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Capture only when the sequencer closes a read window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (cap)
            q <= din;
    end
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
// Access sequencer: walks idle -> strobe phases -> release, drives the
// registered select/strobe/driver controls and the timer loads.
// Assumes the host holds req until ack and drops it after seeing ack.
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned RD_CYC  = 7,
    parameter int unsigned HZ_CYC  = 3,
    parameter int unsigned DAT_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             cap,
    output logic             ack,
    output logic             cs_on,
    output logic             oe_on,
    output logic             we_on,
    output logic             dq_drive
);
    seq_state_t st, nxt;

    // Next-state and timer-load decode.
    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        cap      = 1'b0;
        case (st)
            ST_IDLE: if (req) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                if (wr) begin
                    nxt     = ST_WR_HZ;
                    tmr_val = CNT_W'(HZ_CYC - 1);
                end else begin
                    nxt     = ST_RD_WAIT;
                    tmr_val = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD_WAIT: if (tmr_zero) begin
                nxt = ST_RD_REL;
                cap = 1'b1;
            end
            ST_RD_REL: nxt = ST_IDLE;
            ST_WR_HZ: if (tmr_zero) begin
                nxt      = ST_WR_DAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(DAT_CYC - 1);
            end
            ST_WR_DAT: if (tmr_zero) nxt = ST_WR_REL;
            ST_WR_REL: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register and glitch-free registered pin controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cs_on    <= 1'b0;
            oe_on    <= 1'b0;
            we_on    <= 1'b0;
            dq_drive <= 1'b0;
            ack      <= 1'b0;
        end else begin
            st       <= nxt;
            cs_on    <= (nxt != ST_IDLE);
            oe_on    <= (nxt == ST_RD_WAIT);
            we_on    <= (nxt == ST_WR_HZ) || (nxt == ST_WR_DAT);
            dq_drive <= (nxt == ST_WR_DAT) || (nxt == ST_WR_REL);
            ack      <= (nxt == ST_RD_REL) || (nxt == ST_WR_REL);
        end
    end
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
// Top level of the SRAM access sequencer. Derives every phase length from
// picosecond minimum times and the clock period, holds the request fields
// stable for the whole access and exposes a split tri-state data bus.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_RC_PS   = 70000,
    parameter int unsigned T_AA_PS   = 70000,
    parameter int unsigned T_OE_PS   = 35000,
    parameter int unsigned T_WC_PS   = 70000,
    parameter int unsigned T_WP_PS   = 55000,
    parameter int unsigned T_DW_PS   = 30000,
    parameter int unsigned T_WHZ_PS  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC  = umax(umax(cycles_for(T_RC_PS, CLK_PS),
                                                cycles_for(T_AA_PS, CLK_PS)),
                                           cycles_for(T_OE_PS, CLK_PS));
    localparam int unsigned HZ_CYC  = cycles_for(T_WHZ_PS, CLK_PS);
    localparam int unsigned WL_CYC  = umax(umax(cycles_for(T_WP_PS, CLK_PS),
                                                cycles_for(T_WC_PS, CLK_PS)),
                                           HZ_CYC + cycles_for(T_DW_PS, CLK_PS));
    localparam int unsigned DAT_CYC = WL_CYC - HZ_CYC;
    localparam int unsigned CNT_W   = $clog2(umax(RD_CYC, WL_CYC) + 1);

    logic             tmr_load, tmr_zero, accept, cap;
    logic [CNT_W-1:0] tmr_val;
    logic             cs_on, oe_on, we_on, dq_drive;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_seq #(
        .CNT_W(CNT_W), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .DAT_CYC(DAT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .tmr_zero(tmr_zero),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .accept(accept), .cap(cap),
        .ack(ack), .cs_on(cs_on), .oe_on(oe_on), .we_on(we_on), .dq_drive(dq_drive)
    );

    sram_ctl_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    sram_ctl_rcap #(.DATA_W(DATA_W)) u_rcap (
        .clk(clk), .rst_n(rst_n), .cap(cap), .din(mem_dq_in), .q(rdata)
    );

    // Request fields are latched once at acceptance and held for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_cs1_n  = ~cs_on;
    assign mem_cs2    = cs_on;
    assign mem_oe_n   = ~oe_on;
    assign mem_we_n   = ~we_on;
    assign mem_dq_oe  = dq_drive;
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
// Property checker for the SRAM access sequencer, attached by bind.
// Window lengths are tracked with saturating counters, not deep $past.
module sram_ctl_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned RD_CYC = 7,
    parameter int unsigned HZ_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    logic [7:0] we_low_cnt, oe_low_cnt;

    // Count consecutive cycles with each strobe low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? 8'd0 : ((we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1);
            oe_low_cnt <= mem_oe_n ? 8'd0 : ((oe_low_cnt == 8'hFF) ? oe_low_cnt : oe_low_cnt + 8'd1);
        end
    end

    AST_WE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2)); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs1_n && mem_cs2)); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr)); // R6
    AST_SEL_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs1_n) |-> $past(mem_oe_n && mem_we_n)); // R6
    AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (we_low_cnt >= 8'(HZ_CYC))); // R4
    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(!mem_oe_n)) |-> (oe_low_cnt >= 8'(RD_CYC))); // R3
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
// Bench: behavioural phase model advanced at each rising edge, outputs
// compared at every falling edge; bench-side SRAM answers on the pins.
module sim_sram_ctl;
    localparam int TCLK   = 10;
    localparam int N_RD   = (70 + TCLK - 1) / TCLK;            // max of 70,70,35 ns
    localparam int N_HZ   = (25 + TCLK - 1) / TCLK;            // bus turnaround
    localparam int N_WL   = ((55 + TCLK - 1) / TCLK > (70 + TCLK - 1) / TCLK) ?
                            (55 + TCLK - 1) / TCLK : (70 + TCLK - 1) / TCLK;
    localparam int WDOG   = 100000;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic ack, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rdata, mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic [17:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    logic [7:0] sram [int];
    logic [7:0] shadow [int];
    int ph = -1;
    bit started = 0, m_wr = 0;
    logic [17:0] m_addr = '0;
    logic [7:0]  m_data = '0, e_rdata = '0;

    sram_ctl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #(TCLK/2) clk = ~clk;

    function automatic logic [7:0] fill(input logic [17:0] a);
        return a[7:0] ^ a[17:10];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model: advance the access phase at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = -1; e_rdata = '0; started = 1;
        end else if (ph < 0) begin
            if (req) begin ph = 0; m_wr = wr; m_addr = addr; m_data = wdata; end
        end else begin
            ph++;
            if (ph == (m_wr ? N_WL : N_RD)) begin
                if (m_wr) shadow[int'(m_addr)] = m_data;
                else e_rdata = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : fill(m_addr);
            end else if (ph > (m_wr ? N_WL : N_RD)) ph = -1;
        end
    end

    // Compare at the falling edge, then let the bench SRAM respond.
    always @(negedge clk) begin
        if (started) begin
            int endp;
            bit sel, e_oe, e_we, e_dq, e_ack;
            string tg;
            endp  = m_wr ? N_WL : N_RD;
            sel   = ph >= 0;
            e_oe  = sel && !m_wr && ph < N_RD;
            e_we  = sel && m_wr && ph < N_WL;
            e_dq  = sel && m_wr && ph >= N_HZ;
            e_ack = sel && ph == endp;
            tg = !sel ? "R1" : (e_ack ? "R6" : (m_wr ? "R5" : "R2"));
            chk(tg, {31'd0, mem_cs1_n}, {31'd0, !sel});
            chk(tg, {31'd0, mem_cs2},   {31'd0, sel});
            chk(e_ack ? "R3" : tg, {31'd0, mem_oe_n}, {31'd0, !e_oe});
            chk(tg, {31'd0, mem_we_n},  {31'd0, !e_we});
            chk(m_wr && ph < N_HZ ? "R4" : tg, {31'd0, mem_dq_oe}, {31'd0, e_dq});
            chk(sel ? "R7" : "R1", {31'd0, ack}, {31'd0, e_ack});
            chk("R9", {24'd0, rdata}, {24'd0, e_rdata});
            chk("R8", {31'd0, !(!mem_oe_n && !mem_we_n)}, 32'd1);
            if (sel) chk(ph >= 2 ? "R7" : "R2", {14'd0, mem_addr}, {14'd0, m_addr});
            if (e_dq) chk("R4", {24'd0, mem_dq_out}, {24'd0, m_data});
            if (e_ack && !m_wr) chk("R3", {24'd0, rdata}, {24'd0, e_rdata});
        end
        if (rst_n && !mem_cs1_n && mem_cs2 && !mem_we_n && mem_dq_oe)
            sram[int'(mem_addr)] = mem_dq_out;
        if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n)
            mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : fill(mem_addr);
        else
            mem_dq_in = 8'hEE;
    end

    // Host access: scramble the request fields mid-access to check R7.
    task automatic access(input bit w, input logic [17:0] a, input logic [7:0] d, input int gap);
        @(negedge clk); req = 1; wr = w; addr = a; wdata = d;
        repeat (2) @(negedge clk);
        addr = ~a; wdata = ~d; wr = !w;
        while (!ack) @(negedge clk);
        req = 0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);                  // R1 idle after reset
        access(1, 18'h00000, 8'h5A, 2);             // R4 R5 low boundary
        access(1, 18'h3FFFF, 8'hFF, 0);             // R5 high boundary, back-to-back
        access(1, 18'h12345, 8'h00, 1);
        access(0, 18'h00000, 8'h00, 0);             // R2 R3
        access(0, 18'h3FFFF, 8'h00, 3);
        access(0, 18'h12345, 8'h00, 0);
        access(0, 18'h2AAAA, 8'h00, 1);             // unwritten location
        access(1, 18'h12345, 8'hA5, 0);             // R9 rdata kept across write
        access(0, 18'h12345, 8'h00, 0);             // overwrite visible
        access(1, 18'h00001, 8'h3C, 5);
        access(0, 18'h00001, 8'h00, 4);
        summary();
    end
endmodule